// File: doc/BRIEF.md
# Bandwidth-Limited In-Order Retire Controller

This block is the retire loop of an out-of-order core. Each cycle the reorder buffer shows it a window of the oldest entries of one selected thread, each as a descriptor: ready, kind, executed, squashed, fault, stored next PC, sequence number and one destination mapping. The controller walks the window oldest first. It decides how many entries leave the buffer this cycle and whether the entry at the stopping point needs its can-commit flag cleared. It also raises requests to the execute stage and starts a trap countdown for a faulting entry.

Each commit updates the architectural PC pair of the thread and its committed rename map. The controller reports the youngest committed sequence number and keeps retirement statistics. The buffer reads `pop_cnt` and `clr_head` in the same cycle. All other results are registered.

Instruction kinds are coded on 3 bits: 0 plain, 1 nop, 2 instruction prefetch, 3 load, 4 store, 5 non-speculative, 6 store-conditional, 7 barrier.

Top module: `retire_ctrl`

## Requirements
- R1: Slots are examined from slot 0 upward. Examination stops at the first slot whose ready bit is low, or once WIDTH entries have committed. When `thr_vld` is low nothing retires and `clr_head` stays low. `pop_cnt` is combinational and counts every entry removed this cycle.
- R2: A ready squashed entry is removed, adding to `pop_cnt` but not to the WIDTH count, and changes neither the rename map nor the PC.
- R3: An unexecuted entry of kind 5, 6 or 7 proceeds only when no entry has committed earlier in the cycle and `stores_pend` is low. It then raises `clr_head`, and one cycle later `ns_vld` is high with `ns_uncached` low and `ns_seq` equal to its sequence number. Otherwise it stalls with no request. Either way, examination stops.
- R4: An unexecuted load (kind 3) always raises `clr_head`, and one cycle later `ns_vld` and `ns_uncached` are high with its sequence number. Examination stops. Stores pending and earlier commits do not block it.
- R5: An executed entry with its fault bit set starts a trap only if it would be the first commit of the cycle and `stores_pend` is low. After the next edge `trap_pend` of that thread is high. While it is high, nothing of that thread retires. Otherwise the fault entry stalls.
- R6: `trap_fire` of a thread pulses for one cycle TRAP_LAT clock edges after the edge that accepted the fault, and `trap_pend` drops in the same cycle.
- R7: After any cycle with at least one commit, `done_vld` is high for one cycle and `done_seq` holds the youngest committed sequence number, with `done_tid` the thread.
- R8: Each committed entry with its destination valid maps its architectural register to its physical register in the thread's committed map. Later slots win. The read port returns `map_rd_phys` one edge after the address. Reset sets thread t, register a to t*NARCH+a.
- R9: After a commit cycle the thread's PC equals the stored next PC of its youngest committed entry, and its next PC is that value plus ISZ. Reset gives RESET_PC and RESET_PC+ISZ.
- R10: `stat_insts` adds each committed entry except kinds 1 and 2. Histogram bin k counts cycles with k commits. `stat_full` counts cycles with WIDTH commits.
- R11: Reset clears all registered outputs and statistics.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| thr_vld | input | 1 | a thread is selected this cycle |
| thr_id | input | TW | selected thread |
| stores_pend | input | 1 | stores still awaiting writeback |
| slot_rdy | input | WIN | slot present and ready |
| slot_kind | input | WIN*3 | kind code per slot |
| slot_exec | input | WIN | slot executed |
| slot_sqsh | input | WIN | slot squashed |
| slot_flt | input | WIN | slot faulted |
| slot_npc | input | WIN*AW | stored next PC per slot |
| slot_seq | input | WIN*SW | sequence number per slot |
| slot_dv | input | WIN | destination valid |
| slot_da | input | WIN*RW | architectural destination |
| slot_dp | input | WIN*PW | physical destination |
| map_rd_tid | input | TW | map read thread |
| map_rd_arch | input | RW | map read register |
| map_rd_phys | output | PW | map read data, one-edge latency |
| pop_cnt | output | PCW | entries removed this cycle |
| clr_head | output | 1 | clear can-commit of the stopping slot |
| done_vld | output | 1 | a commit happened last cycle |
| done_tid | output | TW | thread of done_seq |
| done_seq | output | SW | youngest committed sequence |
| ns_vld | output | 1 | execute request issued |
| ns_uncached | output | 1 | request is an uncached load |
| ns_tid | output | TW | thread of request |
| ns_seq | output | SW | sequence of request |
| trap_pend | output | NTHR | trap countdown active per thread |
| trap_fire | output | NTHR | trap countdown expired pulse |
| arch_pc | output | NTHR*AW | architectural PC per thread |
| arch_npc | output | NTHR*AW | architectural next PC per thread |
| stat_hist | output | (WIDTH+1)*CW | commits-per-cycle histogram |
| stat_full | output | CW | cycles at full width |
| stat_insts | output | CW | counted committed instructions |

## Verification
Some rules are checked by properties on every cycle. An idle selection never retires. A trap of the selected thread blocks retirement while it is pending. A serialising request or a newly pending trap never follows a cycle with stores pending. A trap pulse always ends a pending period. A done report always follows a cycle that removed entries. Other results only the bench scenarios can show: the exact count removed for each mix of squashed, stalled and committed slots, the sequence numbers reported, the map and PC contents after many commits, the histogram totals, and the exact trap latency.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [2:0] {
    K_PLAIN  = 3'd0,
    K_NOP    = 3'd1,
    K_IPREF  = 3'd2,
    K_LOAD   = 3'd3,
    K_STORE  = 3'd4,
    K_NSPEC  = 3'd5,
    K_STCOND = 3'd6,
    K_BARR   = 3'd7
  } kind_e;

  function automatic logic is_serial(input logic [2:0] k);
    return (k == K_NSPEC) || (k == K_STCOND) || (k == K_BARR);
  endfunction

  function automatic logic is_uncounted(input logic [2:0] k);
    return (k == K_NOP) || (k == K_IPREF);
  endfunction
endpackage

// File: rtl/retire_scan.sv
module retire_scan import retire_pkg::*; #(
  parameter int WIN   = 4,
  parameter int WIDTH = 2,
  localparam int PCW = $clog2(WIN + 1),
  localparam int NCW = $clog2(WIDTH + 1),
  localparam int IW  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic              en,
  input  logic              stores_pend,
  input  logic [WIN-1:0]    rdy,
  input  logic [WIN*3-1:0]  kind,
  input  logic [WIN-1:0]    exec,
  input  logic [WIN-1:0]    sqsh,
  input  logic [WIN-1:0]    flt,
  output logic [PCW-1:0]    pop,
  output logic [NCW-1:0]    ncommit,
  output logic [NCW-1:0]    ncount,
  output logic [WIN-1:0]    cmask,
  output logic              any,
  output logic [IW-1:0]     last_idx,
  output logic [IW-1:0]     stop_idx,
  output logic              clr,
  output logic              req,
  output logic              unc,
  output logic              ftake
);
  always_comb begin
    logic stop;
    pop = '0; ncommit = '0; ncount = '0; cmask = '0; any = 1'b0;
    last_idx = '0; stop_idx = '0; clr = 1'b0; req = 1'b0; unc = 1'b0;
    ftake = 1'b0;
    stop = !en;
    for (int i = 0; i < WIN; i++) begin
      if (!stop) begin
        if (!rdy[i] || ncommit == NCW'(WIDTH)) begin
          stop = 1'b1;
        end else if (sqsh[i]) begin
          pop = pop + 1'b1;
        end else if (exec[i] && !flt[i]) begin
          pop = pop + 1'b1;
          ncommit = ncommit + 1'b1;
          cmask[i] = 1'b1;
          any = 1'b1;
          last_idx = IW'(i);
          if (!is_uncounted(kind[i*3 +: 3])) ncount = ncount + 1'b1;
        end else if (exec[i]) begin
          stop_idx = IW'(i);
          if (ncommit == '0 && !stores_pend) ftake = 1'b1;
          stop = 1'b1;
        end else if (kind[i*3 +: 3] == K_LOAD) begin
          stop_idx = IW'(i);
          clr = 1'b1; req = 1'b1; unc = 1'b1;
          stop = 1'b1;
        end else if (is_serial(kind[i*3 +: 3])) begin
          stop_idx = IW'(i);
          if (ncommit == '0 && !stores_pend) begin
            clr = 1'b1; req = 1'b1;
          end
          stop = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/retire_state.sv
module retire_state #(
  parameter int WIN      = 4,
  parameter int NTHR     = 2,
  parameter int AW       = 32,
  parameter int NARCH    = 32,
  parameter int NPHYS    = 128,
  parameter int ISZ      = 4,
  parameter logic [AW-1:0] RESET_PC = 32'h1000,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int RW = $clog2(NARCH),
  localparam int PW = $clog2(NPHYS),
  localparam int IW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any,
  input  logic [TW-1:0]      tid,
  input  logic [IW-1:0]      last_idx,
  input  logic [WIN-1:0]     cmask,
  input  logic [WIN-1:0]     dv,
  input  logic [WIN*RW-1:0]  da,
  input  logic [WIN*PW-1:0]  dp,
  input  logic [WIN*AW-1:0]  npc,
  input  logic [TW-1:0]      rd_tid,
  input  logic [RW-1:0]      rd_arch,
  output logic [PW-1:0]      rd_phys,
  output logic [NTHR*AW-1:0] arch_pc,
  output logic [NTHR*AW-1:0] arch_npc
);
  logic [PW-1:0] map_q [NTHR][NARCH];
  logic [AW-1:0] pc_q  [NTHR];
  logic [AW-1:0] npc_q [NTHR];
  logic [AW-1:0] npc_last;

  assign npc_last = npc[last_idx*AW +: AW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTHR; t++)
        for (int a = 0; a < NARCH; a++)
          map_q[t][a] <= PW'(t * NARCH + a);
    end else begin
      for (int i = 0; i < WIN; i++)
        if (cmask[i] && dv[i]) map_q[tid][da[i*RW +: RW]] <= dp[i*PW +: PW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_phys <= '0;
    else     rd_phys <= map_q[rd_tid][rd_arch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < NTHR; t++) begin
        pc_q[t]  <= RESET_PC;
        npc_q[t] <= RESET_PC + AW'(ISZ);
      end
    end else if (any) begin
      pc_q[tid]  <= npc_last;
      npc_q[tid] <= npc_last + AW'(ISZ);
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_pc
    assign arch_pc[t*AW +: AW]  = pc_q[t];
    assign arch_npc[t*AW +: AW] = npc_q[t];
  end
endmodule

// File: rtl/retire_stats.sv
module retire_stats #(
  parameter int WIDTH = 2,
  parameter int CW    = 32,
  localparam int NCW = $clog2(WIDTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NCW-1:0]          ncommit,
  input  logic [NCW-1:0]          ncount,
  output logic [(WIDTH+1)*CW-1:0] hist,
  output logic [CW-1:0]           full,
  output logic [CW-1:0]           insts
);
  logic [CW-1:0] bin_q [WIDTH+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= WIDTH; k++) bin_q[k] <= '0;
      full  <= '0;
      insts <= '0;
    end else begin
      bin_q[ncommit] <= bin_q[ncommit] + 1'b1;
      if (ncommit == NCW'(WIDTH)) full <= full + 1'b1;
      insts <= insts + CW'(ncount);
    end
  end

  for (genvar k = 0; k <= WIDTH; k++) begin : g_bin
    assign hist[k*CW +: CW] = bin_q[k];
  end
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int TRAP_LAT = 8,
  localparam int LW = $clog2(TRAP_LAT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pend,
  output logic fire
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; fire <= 1'b0; cnt_q <= '0;
    end else begin
      fire <= 1'b0;
      if (pend) begin
        if (cnt_q == LW'(1)) begin
          pend <= 1'b0;
          fire <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (take) begin
        pend  <= 1'b1;
        cnt_q <= LW'(TRAP_LAT);
      end
    end
  end
endmodule

// File: rtl/retire_ctrl.sv
module retire_ctrl import retire_pkg::*; #(
  parameter int WIN      = 4,
  parameter int WIDTH    = 2,
  parameter int NTHR     = 2,
  parameter int AW       = 32,
  parameter int SW       = 16,
  parameter int NARCH    = 32,
  parameter int NPHYS    = 128,
  parameter int CW       = 32,
  parameter int ISZ      = 4,
  parameter int TRAP_LAT = 8,
  parameter logic [AW-1:0] RESET_PC = 32'h1000,
  localparam int TW  = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int RW  = $clog2(NARCH),
  localparam int PW  = $clog2(NPHYS),
  localparam int PCW = $clog2(WIN + 1),
  localparam int NCW = $clog2(WIDTH + 1),
  localparam int IW  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    thr_vld,
  input  logic [TW-1:0]           thr_id,
  input  logic                    stores_pend,
  input  logic [WIN-1:0]          slot_rdy,
  input  logic [WIN*3-1:0]        slot_kind,
  input  logic [WIN-1:0]          slot_exec,
  input  logic [WIN-1:0]          slot_sqsh,
  input  logic [WIN-1:0]          slot_flt,
  input  logic [WIN*AW-1:0]       slot_npc,
  input  logic [WIN*SW-1:0]       slot_seq,
  input  logic [WIN-1:0]          slot_dv,
  input  logic [WIN*RW-1:0]       slot_da,
  input  logic [WIN*PW-1:0]       slot_dp,
  input  logic [TW-1:0]           map_rd_tid,
  input  logic [RW-1:0]           map_rd_arch,
  output logic [PW-1:0]           map_rd_phys,
  output logic [PCW-1:0]          pop_cnt,
  output logic                    clr_head,
  output logic                    done_vld,
  output logic [TW-1:0]           done_tid,
  output logic [SW-1:0]           done_seq,
  output logic                    ns_vld,
  output logic                    ns_uncached,
  output logic [TW-1:0]           ns_tid,
  output logic [SW-1:0]           ns_seq,
  output logic [NTHR-1:0]         trap_pend,
  output logic [NTHR-1:0]         trap_fire,
  output logic [NTHR*AW-1:0]      arch_pc,
  output logic [NTHR*AW-1:0]      arch_npc,
  output logic [(WIDTH+1)*CW-1:0] stat_hist,
  output logic [CW-1:0]           stat_full,
  output logic [CW-1:0]           stat_insts
);
  logic           scan_en;
  logic [NCW-1:0] ncommit, ncount;
  logic [WIN-1:0] cmask;
  logic           any_c, req_c, unc_c, ftake_c;
  logic [IW-1:0]  last_idx, stop_idx;

  assign scan_en = thr_vld && !trap_pend[thr_id];

  retire_scan #(.WIN(WIN), .WIDTH(WIDTH)) u_scan (
    .en(scan_en), .stores_pend(stores_pend), .rdy(slot_rdy),
    .kind(slot_kind), .exec(slot_exec), .sqsh(slot_sqsh), .flt(slot_flt),
    .pop(pop_cnt), .ncommit(ncommit), .ncount(ncount), .cmask(cmask),
    .any(any_c), .last_idx(last_idx), .stop_idx(stop_idx), .clr(clr_head),
    .req(req_c), .unc(unc_c), .ftake(ftake_c)
  );

  retire_state #(.WIN(WIN), .NTHR(NTHR), .AW(AW), .NARCH(NARCH),
                 .NPHYS(NPHYS), .ISZ(ISZ), .RESET_PC(RESET_PC)) u_state (
    .clk(clk), .rst(rst), .any(any_c), .tid(thr_id), .last_idx(last_idx),
    .cmask(cmask), .dv(slot_dv), .da(slot_da), .dp(slot_dp), .npc(slot_npc),
    .rd_tid(map_rd_tid), .rd_arch(map_rd_arch), .rd_phys(map_rd_phys),
    .arch_pc(arch_pc), .arch_npc(arch_npc)
  );

  retire_stats #(.WIDTH(WIDTH), .CW(CW)) u_stats (
    .clk(clk), .rst(rst), .ncommit(ncommit), .ncount(ncount),
    .hist(stat_hist), .full(stat_full), .insts(stat_insts)
  );

  for (genvar t = 0; t < NTHR; t++) begin : g_trap
    trap_timer #(.TRAP_LAT(TRAP_LAT)) u_tmr (
      .clk(clk), .rst(rst), .take(ftake_c && thr_id == TW'(t)),
      .pend(trap_pend[t]), .fire(trap_fire[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_vld <= 1'b0; done_tid <= '0; done_seq <= '0;
      ns_vld <= 1'b0; ns_uncached <= 1'b0; ns_tid <= '0; ns_seq <= '0;
    end else begin
      done_vld <= any_c;
      if (any_c) begin
        done_tid <= thr_id;
        done_seq <= slot_seq[last_idx*SW +: SW];
      end
      ns_vld      <= req_c;
      ns_uncached <= req_c && unc_c;
      if (req_c) begin
        ns_tid <= thr_id;
        ns_seq <= slot_seq[stop_idx*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/retire_ctrl_chk.sv
module retire_ctrl_chk #(
  parameter int NTHR = 2,
  parameter int TW   = 1,
  parameter int PCW  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            thr_vld,
  input logic [TW-1:0]   thr_id,
  input logic            stores_pend,
  input logic [PCW-1:0]  pop_cnt,
  input logic            clr_head,
  input logic            done_vld,
  input logic            ns_vld,
  input logic            ns_uncached,
  input logic [NTHR-1:0] trap_pend,
  input logic [NTHR-1:0] trap_fire
);
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !thr_vld |-> (pop_cnt == '0 && !clr_head));

  p_serial_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (ns_vld && !ns_uncached) |-> $past(!stores_pend));

  p_done_after_pop_r7: assert property (@(posedge clk) disable iff (rst)
    done_vld |-> $past(pop_cnt) != '0);

  for (genvar t = 0; t < NTHR; t++) begin : g_t
    p_trap_take_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(trap_pend[t]) |-> $past(!stores_pend && thr_vld && thr_id == TW'(t)));

    p_trap_block_r5: assert property (@(posedge clk) disable iff (rst)
      (thr_vld && thr_id == TW'(t) && trap_pend[t]) |-> (pop_cnt == '0 && !clr_head));

    p_fire_end_r6: assert property (@(posedge clk) disable iff (rst)
      trap_fire[t] |-> ($past(trap_pend[t]) && !trap_pend[t]));
  end
endmodule

bind retire_ctrl retire_ctrl_chk #(.NTHR(NTHR), .TW(TW), .PCW(PCW)) u_chk (
  .clk(clk), .rst(rst), .thr_vld(thr_vld), .thr_id(thr_id),
  .stores_pend(stores_pend), .pop_cnt(pop_cnt), .clr_head(clr_head),
  .done_vld(done_vld), .ns_vld(ns_vld), .ns_uncached(ns_uncached),
  .trap_pend(trap_pend), .trap_fire(trap_fire)
);

// File: tb/sim_retire_ctrl.sv
`timescale 1ns/1ps
module sim_retire_ctrl;
  localparam int WIN = 4, WIDTH = 2, NTHR = 2, AW = 32, SW = 16;
  localparam int NARCH = 32, NPHYS = 128, CW = 16, ISZ = 4, TRAP_LAT = 5;
  localparam int RW = 5, PW = 7, PCW = 3;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic thr_vld, thr_id, stores_pend;
  logic [WIN-1:0] slot_rdy, slot_exec, slot_sqsh, slot_flt, slot_dv;
  logic [WIN*3-1:0] slot_kind;
  logic [WIN*AW-1:0] slot_npc;
  logic [WIN*SW-1:0] slot_seq;
  logic [WIN*RW-1:0] slot_da;
  logic [WIN*PW-1:0] slot_dp;
  logic map_rd_tid;
  logic [RW-1:0] map_rd_arch;
  logic [PW-1:0] map_rd_phys;
  logic [PCW-1:0] pop_cnt;
  logic clr_head, done_vld, done_tid, ns_vld, ns_uncached, ns_tid;
  logic [SW-1:0] done_seq, ns_seq;
  logic [NTHR-1:0] trap_pend, trap_fire;
  logic [NTHR*AW-1:0] arch_pc, arch_npc;
  logic [(WIDTH+1)*CW-1:0] stat_hist;
  logic [CW-1:0] stat_full, stat_insts;

  retire_ctrl #(.WIN(WIN), .WIDTH(WIDTH), .NTHR(NTHR), .AW(AW), .SW(SW),
    .NARCH(NARCH), .NPHYS(NPHYS), .CW(CW), .ISZ(ISZ), .TRAP_LAT(TRAP_LAT),
    .RESET_PC(32'h1000)) u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slot code: bit6 ready, bit5 squashed, bit4 executed, bit3 fault, [2:0] kind
  task automatic set_slot(input int v, input int i, input logic [6:0] c);
    slot_rdy[i]  = c[6];
    slot_sqsh[i] = c[5];
    slot_exec[i] = c[4];
    slot_flt[i]  = c[3];
    slot_kind[i*3 +: 3] = c[2:0];
    slot_dv[i] = c[4] && c[2:0] != 3'd1 && c[2:0] != 3'd2;
    slot_seq[i*SW +: SW] = SW'(v * 16 + i);
    slot_npc[i*AW +: AW] = AW'(32'h100 * v + 16 * i + 4);
    slot_da[i*RW +: RW] = RW'(v * 4 + i);
    slot_dp[i*PW +: PW] = PW'(v * 4 + i + 64);
  endtask

  task automatic idle_slots();
    for (int i = 0; i < WIN; i++) set_slot(0, i, 7'h00);
  endtask

  typedef struct packed {
    logic thrv; logic st;
    logic [6:0] s0; logic [6:0] s1; logic [6:0] s2; logic [6:0] s3;
    logic [2:0] pop; logic clr; logic ns; logic unc; logic dv;
    logic [1:0] di; logic [1:0] ic;
  } vec_t;

  localparam logic [6:0] A = 7'h50, SQ = 7'h60, SER = 7'h45, LD = 7'h43;
  localparam logic [6:0] NR = 7'h00, NOP = 7'h51, IPF = 7'h52, FLT = 7'h58;

  localparam vec_t TBL [12] = '{
    '{1'b1, 1'b0, A,   A,   A,  A, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd2}, // R1 width cap
    '{1'b1, 1'b0, SQ,  SQ,  A,  A, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2}, // R2 free drain
    '{1'b1, 1'b0, A,   SER, A,  A, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1}, // R3 not first
    '{1'b1, 1'b0, SER, A,   A,  A, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0}, // R3 first
    '{1'b1, 1'b1, SER, A,   A,  A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R3 stores
    '{1'b1, 1'b1, LD,  A,   A,  A, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0}, // R4 stores
    '{1'b1, 1'b0, A,   LD,  A,  A, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 2'd1}, // R4 after commit
    '{1'b1, 1'b0, A,   NR,  A,  A, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1}, // R1 gap
    '{1'b1, 1'b0, NR,  A,   A,  A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 head not ready
    '{1'b1, 1'b0, NOP, IPF, A,  A, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0}, // R10 uncounted
    '{1'b1, 1'b0, SQ,  A,   SQ, A, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2}, // R2 interleaved
    '{1'b0, 1'b0, A,   A,   A,  A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}  // R1 no thread
  };

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ic_sum;
    int fire_at;
    thr_vld = 1'b0; thr_id = 1'b0; stores_pend = 1'b0;
    map_rd_tid = 1'b0; map_rd_arch = 5'd5;
    idle_slots();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    // R11 reset state
    check("R11 pop", 64'(pop_cnt), 64'd0);
    check("R11 done_vld", 64'(done_vld), 64'd0);
    check("R11 ns_vld", 64'(ns_vld), 64'd0);
    check("R11 stat_insts", 64'(stat_insts), 64'd0);
    check("R11 trap_pend", 64'(trap_pend), 64'd0);
    check("R9 reset pc", 64'(arch_pc[0 +: AW]), 64'h1000);
    check("R9 reset npc", 64'(arch_npc[0 +: AW]), 64'h1004);
    check("R8 reset map", 64'(map_rd_phys), 64'd5);

    ic_sum = 0;
    for (int v = 0; v < 12; v++) begin
      @(negedge clk);
      thr_vld = TBL[v].thrv; thr_id = 1'b0; stores_pend = TBL[v].st;
      set_slot(v, 0, TBL[v].s0); set_slot(v, 1, TBL[v].s1);
      set_slot(v, 2, TBL[v].s2); set_slot(v, 3, TBL[v].s3);
      #1;
      check($sformatf("R1 pop v%0d", v), 64'(pop_cnt), 64'(TBL[v].pop));
      check($sformatf("R3 clr v%0d", v), 64'(clr_head), 64'(TBL[v].clr));
      @(posedge clk); #1;
      check($sformatf("R7 done_vld v%0d", v), 64'(done_vld), 64'(TBL[v].dv));
      if (TBL[v].dv)
        check($sformatf("R7 done_seq v%0d", v), 64'(done_seq), 64'(v * 16 + TBL[v].di));
      check($sformatf("R3 ns_vld v%0d", v), 64'(ns_vld), 64'(TBL[v].ns));
      if (TBL[v].ns) begin
        check($sformatf("R4 ns_uncached v%0d", v), 64'(ns_uncached), 64'(TBL[v].unc));
        check($sformatf("R3 ns_seq v%0d", v), 64'(ns_seq), 64'(v * 16 + TBL[v].pop));
      end
      ic_sum += TBL[v].ic;
      thr_vld = 1'b0; idle_slots();
    end

    // R10 statistics
    check("R10 stat_insts", 64'(stat_insts), 64'(ic_sum));
    check("R10 full cycles", 64'(stat_full), 64'd4);
    check("R10 hist bin2", 64'(stat_hist[2*CW +: CW]), 64'd4);
    check("R10 hist bin1", 64'(stat_hist[1*CW +: CW]), 64'd3);
    // R9 PC after last commit of thread 0 (vector 10 slot 3)
    check("R9 pc t0", 64'(arch_pc[0 +: AW]), 64'hA34);
    check("R9 npc t0", 64'(arch_npc[0 +: AW]), 64'hA38);
    check("R9 pc t1 untouched", 64'(arch_pc[AW +: AW]), 64'h1000);
    // R8 map contents
    map_rd_tid = 1'b0; map_rd_arch = 5'd11;
    @(posedge clk); #1;
    check("R8 map t0 r11", 64'(map_rd_phys), 64'd107);
    map_rd_arch = 5'd10;
    @(posedge clk); #1;
    check("R2 squashed no map write", 64'(map_rd_phys), 64'd10);
    map_rd_tid = 1'b1; map_rd_arch = 5'd11;
    @(posedge clk); #1;
    check("R8 map t1 untouched", 64'(map_rd_phys), 64'd43);

    // R5 fault not first
    @(negedge clk);
    thr_vld = 1'b1; thr_id = 1'b1; stores_pend = 1'b0;
    set_slot(1, 0, A); set_slot(1, 1, FLT); set_slot(1, 2, NR); set_slot(1, 3, NR);
    #1 check("R5 fault after commit pop", 64'(pop_cnt), 64'd1);
    @(posedge clk); #1;
    check("R5 no trap when not first", 64'(trap_pend), 64'd0);
    // R5 fault with stores pending
    set_slot(2, 0, FLT); set_slot(2, 1, A); stores_pend = 1'b1;
    @(posedge clk); #1;
    check("R5 no trap with stores", 64'(trap_pend), 64'd0);
    // R5 fault accepted
    stores_pend = 1'b0;
    #1 check("R5 fault stalls pop", 64'(pop_cnt), 64'd0);
    @(posedge clk); #1;
    check("R5 trap pending t1", 64'(trap_pend), 64'b10);
    set_slot(3, 0, A); set_slot(3, 1, A);
    #1 check("R5 blocked while pending", 64'(pop_cnt), 64'd0);
    thr_id = 1'b0;
    #1 check("R5 other thread free", 64'(pop_cnt), 64'd2);
    thr_vld = 1'b0; idle_slots();
    fire_at = 0;
    for (int j = 1; j <= 10; j++) begin
      @(posedge clk); #1;
      if (trap_fire[1] && fire_at == 0) begin
        fire_at = j;
        check("R6 pend clears with fire", 64'(trap_pend[1]), 64'd0);
      end
    end
    check("R6 trap latency", 64'(fire_at), 64'(TRAP_LAT));
    check("R6 single pulse", 64'(trap_fire), 64'd0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule